// File: doc/BRIEF.md
# Serial EEPROM Target with Software Write Protection

This block is a two-wire serial-bus target in front of a 256-byte register-backed memory. It decodes memory writes, immediate reads and selective reads (a write frame that carries only a word address, followed by a repeated START and a read). It keeps the internal address counter that reads use, and it decides, byte by byte, whether to pull SDA low in the acknowledge slot.

Two protect switches guard the lower half of the array. One switch is reversible. The other, once set, stays set until reset. Both are driven by frames that carry their own device-type code. Whether such a frame is acknowledged depends on three things: the permanent switch, the write-protect pin, and whether the command would actually change a switch or only repeat its present state.

The block expects SCL and SDA already synchronized to `clk`. It produces one pull-low enable for SDA. A reset input stands in for power-on detection. A memory write completes in the single clock cycle in which its data byte is accepted.

Top module: `swp_eeprom`

## Requirements
- R1: After reset, SDA is released, both switches are clear, the address counter is 0x00 and every memory byte reads 0x00.
- R2: Bits travel MSB first. A device byte whose bits [7:4] are 4'b1010 and whose bits [3:1] equal `chip_sel_i` is acknowledged for either R/W (bit 0). Bit 0 = 0 means write and 1 means read. Any other device byte is refused, including a protect code (bits [7:4] = 4'b0110) with bit 0 = 1, and the rest of that frame is ignored.
- R3: In a memory write, the word-address byte is acknowledged and loads the address counter. Each acknowledged data byte is stored at the counter, and the counter then steps up by one, wrapping from 0xFF to 0x00.
- R4: A read sends the byte at the address counter MSB first and advances the counter, wrapping past 0xFF. A master acknowledge requests the next byte. A master no-acknowledge ends the transfer and leaves SDA released.
- R5: A protect frame with command bits [3:1] = 3'b001 sets the reversible switch. While either switch is set, data bytes aimed at 0x00–0x7F are refused and change nothing. Data bytes aimed at 0x80–0xFF are still written.
- R6: Command bits [3:1] = 3'b011 clear the reversible switch, which unlocks the lower half again.
- R7: Any other command value requests the permanent switch. The device byte, the don't-care word address and the don't-care data byte are all acknowledged. The switch takes effect only at the STOP that closes the frame, and the lower half is then locked.
- R8: Once the permanent switch is set, every protect device byte is refused, whatever its command, and the switch never clears.
- R9: With WP high, a protect command that would change a switch has its device byte and word address acknowledged, but its data byte is refused and neither switch changes.
- R10: A protect command that only repeats the present state of the reversible switch is refused at the device byte, at either WP level.
- R11: With WP high, every memory data byte is refused and the memory is left unchanged.
- R12: A repeated START in place of the STOP discards an accepted protect command.
- R13: The SDA pull-low enable changes only while SCL is low. It is never asserted while the master owns a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| wp_i | input | 1 | Write-protect pin, high blocks all writes |
| chip_sel_i | input | 3 | Expected chip-select bits of the memory device byte |
| sda_pull_o | output | 1 | Pull SDA low when 1 |

## Verification
Memory traffic is tried in several forms:
- plain multi-byte writes;
- a write that crosses 0xFF, which separates correct wrap-around from saturation;
- selective and immediate reads, which show that a word address loads the counter and that reads advance it;
- WP-high writes.

Protect frames are sent in every relevant combination of switch state, command code and WP level. This separates the three refusal points: the device byte for repeated or post-permanent commands, the data byte for WP, and no refusal at all. After each protect frame, writes to both halves of the array show which switches actually changed. A protect frame closed by a repeated START shows that a command takes effect only on STOP.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam logic [3:0] MEM_CODE  = 4'b1010;
    localparam logic [3:0] PROT_CODE = 4'b0110;
    localparam logic [2:0] CMD_REV_ON  = 3'b001;
    localparam logic [2:0] CMD_REV_OFF = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
    } st_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_REV_ON, PEND_REV_OFF, PEND_PERM
    } pend_e;

    typedef enum logic {FR_MEM, FR_PROT} frame_e;
endpackage

// File: rtl/swp_bus_cond.sv
module swp_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl = scl_i;
        smp_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{scl: 1'b1, sda: 1'b1};
        else        smp_q <= smp_d;
    end

    // conditions are seen one sample after the line moves
    assign scl_rise_o = scl_i & ~smp_q.scl;
    assign scl_fall_o = ~scl_i & smp_q.scl;
    assign start_o    = scl_i & smp_q.scl & smp_q.sda & ~sda_i;
    assign stop_o     = scl_i & smp_q.scl & ~smp_q.sda & sda_i;
endmodule

// File: rtl/swp_mem_array.sv
module swp_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en_i && (wr_addr_i == ADDR_W'(g))) word_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[g] = word_q;
    end

    assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/swp_proto_ctrl.sv
module swp_proto_ctrl
    import swp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              wp_i,
    input  logic [SEL_W-1:0]  chip_sel_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              sda_pull_o,
    output logic              rev_o,
    output logic              perm_o
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    typedef struct packed {
        st_e               st;
        st_e               after;
        frame_e            frame;
        pend_e             cmd;
        pend_e             pend;
        logic [7:0]        shreg;
        logic [3:0]        bits;
        logic [ADDR_W-1:0] cnt;
        logic              pull;
        logic              rev;
        logic              perm;
        logic              mack;
    } ctrl_t;

    ctrl_t d, q;
    logic        ack;
    logic        restate;
    logic        writable;
    logic [2:0]  code;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_addr_o = q.cnt;
        wr_data_o = q.shreg;
        ack       = 1'b0;
        code      = q.shreg[3:1];
        restate   = ((code == CMD_REV_ON) && q.rev) || ((code == CMD_REV_OFF) && !q.rev);
        writable  = !wp_i && !((q.rev || q.perm) && !q.cnt[ADDR_W-1]);

        if (start_i) begin
            d.st   = ST_DEV;
            d.bits = '0;
            d.pull = 1'b0;
            d.pend = PEND_NONE;
        end else if (stop_i) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
            d.pend = PEND_NONE;
            unique case (q.pend)
                PEND_REV_ON:  d.rev  = 1'b1;
                PEND_REV_OFF: d.rev  = 1'b0;
                PEND_PERM:    d.perm = 1'b1;
                default:      ;
            endcase
        end else begin
            unique case (q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise_i && (q.bits != BYTE_BITS)) begin
                        d.shreg = {q.shreg[6:0], sda_i};
                        d.bits  = q.bits + 4'd1;
                    end else if (scl_fall_i && (q.bits == BYTE_BITS)) begin
                        d.bits  = '0;
                        d.st    = ST_ACK;
                        d.after = ST_IDLE;
                        if (q.st == ST_DEV) begin
                            if ((q.shreg[7:4] == MEM_CODE) && (q.shreg[3:1] == chip_sel_i)) begin
                                ack     = 1'b1;
                                d.frame = FR_MEM;
                                d.after = q.shreg[0] ? ST_RDATA : ST_WADDR;
                            end else if ((q.shreg[7:4] == PROT_CODE) && !q.shreg[0]) begin
                                ack     = !q.perm && !restate;
                                d.frame = FR_PROT;
                                d.cmd   = (code == CMD_REV_ON)  ? PEND_REV_ON  :
                                          (code == CMD_REV_OFF) ? PEND_REV_OFF : PEND_PERM;
                                if (ack) d.after = ST_WADDR;
                            end
                        end else if (q.st == ST_WADDR) begin
                            ack     = 1'b1;
                            d.after = ST_WDATA;
                            if (q.frame == FR_MEM) d.cnt = q.shreg[ADDR_W-1:0];
                        end else if (q.frame == FR_MEM) begin
                            if (writable) begin
                                ack     = 1'b1;
                                wr_en_o = 1'b1;
                                d.cnt   = q.cnt + 1'b1;
                                d.after = ST_WDATA;
                            end
                        end else if (!wp_i) begin
                            ack    = 1'b1;
                            d.pend = q.cmd;
                        end
                        d.pull = ack;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (q.after == ST_RDATA) begin
                            d.shreg = rd_data_i;
                            d.pull  = ~rd_data_i[7];
                            d.bits  = 4'd1;
                            d.cnt   = q.cnt + 1'b1;
                            d.st    = ST_RDATA;
                        end else begin
                            d.pull = 1'b0;
                            d.st   = q.after;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall_i) begin
                        if (q.bits == BYTE_BITS) begin
                            d.pull = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.pull  = ~q.shreg[6];
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.bits  = q.bits + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.shreg = rd_data_i;
                            d.pull  = ~rd_data_i[7];
                            d.bits  = 4'd1;
                            d.cnt   = q.cnt + 1'b1;
                            d.st    = ST_RDATA;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, after: ST_IDLE, frame: FR_MEM, cmd: PEND_NONE,
                   pend: PEND_NONE, shreg: '0, bits: '0, cnt: '0, pull: 1'b0,
                   rev: 1'b0, perm: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o  = q.cnt;
    assign sda_pull_o = q.pull;
    assign rev_o      = q.rev;
    assign perm_o     = q.perm;
endmodule

// File: rtl/swp_eeprom.sv
module swp_eeprom #(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             wp_i,
    input  logic [SEL_W-1:0] chip_sel_i,
    output logic             sda_pull_o
);
    localparam int DATA_W = 8;

    logic              bus_rise, bus_fall, bus_start, bus_stop;
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr, mem_rd_addr;
    logic [DATA_W-1:0] mem_wr_data, mem_rd_data;
    logic              sw_rev, sw_perm;

    swp_bus_cond u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (bus_rise),
        .scl_fall_o (bus_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    swp_proto_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (bus_rise),
        .scl_fall_i (bus_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .sda_i      (sda_i),
        .wp_i       (wp_i),
        .chip_sel_i (chip_sel_i),
        .rd_data_i  (mem_rd_data),
        .rd_addr_o  (mem_rd_addr),
        .wr_en_o    (mem_wr_en),
        .wr_addr_o  (mem_wr_addr),
        .wr_data_o  (mem_wr_data),
        .sda_pull_o (sda_pull_o),
        .rev_o      (sw_rev),
        .perm_o     (sw_perm)
    );

    swp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (mem_wr_en),
        .wr_addr_i (mem_wr_addr),
        .wr_data_i (mem_wr_data),
        .rd_addr_i (mem_rd_addr),
        .rd_data_o (mem_rd_data)
    );
endmodule

// File: rtl/swp_eeprom_chk.sv
module swp_eeprom_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              wp_i,
    input logic              sda_pull,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rev,
    input logic              perm,
    input logic              stop_det
);
    // R8
    perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm |=> perm);

    // R7
    perm_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perm) |-> $past(stop_det));

    // R6
    rev_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev) |-> $past(stop_det));

    // R5
    low_half_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rev || perm)) |-> wr_addr[ADDR_W-1]);

    // R11
    wp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wp_i);

    // R13
    pull_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_i);
endmodule

bind swp_eeprom swp_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .wp_i     (wp_i),
    .sda_pull (sda_pull_o),
    .wr_en    (mem_wr_en),
    .wr_addr  (mem_wr_addr),
    .rev      (sw_rev),
    .perm     (sw_perm),
    .stop_det (bus_stop)
);

// File: tb/swp_eeprom_tb.sv
module swp_eeprom_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] sel = 3'b101;
    logic       sda_pull;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    swp_eeprom u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .wp_i       (wp),
        .chip_sel_i (sel),
        .sda_pull_o (sda_pull)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  master_owns = 1'b0;
    int  own_viol = 0;

    // behavioural reference state
    byte unsigned mem_m [256];
    int  cnt_m  = 0;
    bit  rev_m  = 1'b0;
    bit  perm_m = 1'b0;
    int  pend_m = 0;   // 0 none, 1 rev on, 2 rev off, 3 permanent

    // every clock: the target must leave SDA alone while the master drives a bit
    always @(negedge clk) if (rst_n && master_owns && sda_pull) own_viol++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(2); sda_m = 1'b1; tick(2);
        scl = 1'b1; tick(2); sda_m = 1'b0; tick(2);
        pend_m = 0;
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(2); sda_m = 1'b0; tick(2);
        scl = 1'b1; tick(2); sda_m = 1'b1; tick(4);
        case (pend_m)
            1: rev_m = 1'b1;
            2: rev_m = 1'b0;
            3: perm_m = 1'b1;
            default: ;
        endcase
        pend_m = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; tick(2); sda_m = b[i]; master_owns = 1'b1; tick(2);
            scl = 1'b1; tick(4); master_owns = 1'b0;
        end
        scl = 1'b0; tick(2); sda_m = 1'b1; tick(2);
        scl = 1'b1; tick(2); ack = (sda_bus == 1'b0); tick(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; tick(2); sda_m = 1'b1; tick(2);
            scl = 1'b1; tick(2); b[i] = sda_bus; tick(2);
        end
        scl = 1'b0; tick(2); sda_m = ~mack; tick(2);
        scl = 1'b1; tick(4);
    endtask

    // write or protect frame, expected acknowledges come from the reference state
    task automatic wr_frame(input logic [7:0] dev, input logic [7:0] wa, input int n,
                            input logic [7:0] d0, input bit do_stop, input string req);
        bit a, exp;
        int kind, cmd;
        logic [7:0] dv;
        kind = 0;
        if (dev[7:4] == 4'b1010 && dev[3:1] == sel) kind = 1;
        else if (dev[7:4] == 4'b0110 && !dev[0]) kind = 2;
        cmd = (dev[3:1] == 3'b001) ? 1 : (dev[3:1] == 3'b011) ? 2 : 3;
        bus_start();
        send_byte(dev, a);
        if (kind == 1) exp = 1'b1;
        else if (kind == 2) exp = !perm_m && !((cmd == 1 && rev_m) || (cmd == 2 && !rev_m));
        else exp = 1'b0;
        chk({req, " device ack"}, a, exp);
        if (!exp) begin
            bus_stop();
            return;
        end
        send_byte(wa, a);
        chk({req, " word ack"}, a, 1);
        if (kind == 1) cnt_m = wa;
        for (int i = 0; i < n; i++) begin
            dv = d0 + 8'(i);
            send_byte(dv, a);
            if (kind == 1) begin
                exp = !wp && !((rev_m || perm_m) && cnt_m < 128);
                if (exp) begin
                    mem_m[cnt_m] = dv;
                    cnt_m = (cnt_m + 1) % 256;
                end
            end else begin
                exp = !wp;
                if (exp) pend_m = cmd;
            end
            chk({req, " data ack"}, a, exp);
            if (!exp) break;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_frame(input int n, input string req);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, sel, 1'b1}, a);
        chk({req, " read device ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk({req, " read data"}, b, mem_m[cnt_m]);
            cnt_m = (cnt_m + 1) % 256;
        end
        bus_stop();
    endtask

    task automatic sel_read(input logic [7:0] wa, input int n, input string req);
        wr_frame({4'b1010, sel, 1'b0}, wa, 0, 8'h00, 1'b0, req);
        rd_frame(n, req);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R1 pull released after reset", sda_pull, 0);
        rd_frame(2, "R1 counter zero and memory clear");

        // R3 / R4 plain write and reads
        wr_frame(8'hAA, 8'h10, 3, 8'h5C, 1'b1, "R3 write three bytes");
        sel_read(8'h10, 3, "R4 selective read");
        rd_frame(1, "R4 immediate read follows counter");
        // R3 wrap on write, R4 wrap on read
        wr_frame(8'hAA, 8'hFF, 2, 8'hC3, 1'b1, "R3 write across 0xFF");
        rd_frame(1, "R3 counter after wrap");
        sel_read(8'hFF, 3, "R4 read across 0xFF");

        // R2 device decoding
        wr_frame(8'hA2, 8'h40, 1, 8'h11, 1'b1, "R2 wrong chip select");
        wr_frame(8'h63, 8'h00, 1, 8'h00, 1'b1, "R2 protect code with read bit");
        sel_read(8'h40, 1, "R2 refused frame wrote nothing");

        // R11 WP blocks memory writes
        wp = 1'b1;
        wr_frame(8'hAA, 8'h90, 1, 8'h77, 1'b1, "R11 write with WP high");
        wp = 1'b0;
        sel_read(8'h90, 1, "R11 memory unchanged");

        // R5 reversible switch on
        wr_frame(8'h62, 8'h00, 1, 8'h00, 1'b1, "R5 reversible set");
        wr_frame(8'hAA, 8'h20, 1, 8'h31, 1'b1, "R5 lower half refused");
        wr_frame(8'hAA, 8'h85, 2, 8'h42, 1'b1, "R5 upper half written");
        sel_read(8'h1F, 3, "R5 lower half unchanged");
        sel_read(8'h85, 2, "R5 upper half readback");

        // R10 repeated state refused at either WP level
        wr_frame(8'h62, 8'h00, 1, 8'h00, 1'b1, "R10 set again, WP low");
        wp = 1'b1;
        wr_frame(8'h62, 8'h00, 1, 8'h00, 1'b1, "R10 set again, WP high");

        // R9 WP high blocks a changing command
        wr_frame(8'h66, 8'h00, 1, 8'h00, 1'b1, "R9 clear with WP high");
        wp = 1'b0;
        wr_frame(8'hAA, 8'h21, 1, 8'h55, 1'b1, "R9 switch still set");

        // R6 clear reversible
        wr_frame(8'h66, 8'h00, 1, 8'h00, 1'b1, "R6 reversible clear");
        wr_frame(8'hAA, 8'h20, 1, 8'h31, 1'b1, "R6 lower half writable");
        wr_frame(8'h66, 8'h00, 1, 8'h00, 1'b1, "R10 clear again refused");

        // R12 repeated START discards the command
        wr_frame(8'h62, 8'h00, 1, 8'h00, 1'b0, "R12 set then restart");
        rd_frame(1, "R12 read after restart");
        wr_frame(8'hAA, 8'h22, 1, 8'h66, 1'b1, "R12 switch not set");

        // R7 permanent switch
        wr_frame(8'h6A, 8'h5A, 1, 8'hA5, 1'b1, "R7 permanent set");
        wr_frame(8'hAA, 8'h23, 1, 8'h12, 1'b1, "R7 lower half refused");
        wr_frame(8'hAA, 8'hA0, 1, 8'h34, 1'b1, "R7 upper half written");
        sel_read(8'h20, 4, "R7 lower half content");

        // R8 all protect commands refused afterwards
        wr_frame(8'h62, 8'h00, 1, 8'h00, 1'b1, "R8 reversible set refused");
        wr_frame(8'h66, 8'h00, 1, 8'h00, 1'b1, "R8 reversible clear refused");
        wr_frame(8'h60, 8'h00, 1, 8'h00, 1'b1, "R8 permanent refused");
        wr_frame(8'hAA, 8'h24, 1, 8'h99, 1'b1, "R8 lower half still locked");

        chk("R13 target idle while master drives", own_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule